// File: doc/BRIEF.md
# Block Address Translation Matcher

This block translates a 32-bit effective address through a small set of block translation entries. Each entry has an upper word and a lower word. The upper word holds the effective block index, the block length and two validity bits, one for user mode and one for supervisor mode. The lower word holds the real block base and the protection field. Instruction fetches and data accesses each have their own entry set, so an entry loaded on one side never translates accesses on the other side.

The block compares the address against every entry of the selected side in the same cycle. The lowest-numbered matching entry supplies the real address, truncated to a 4 KB page, and its protection bits. The block length in each entry widens its compare mask, so one entry can cover anywhere from 128 KB to 256 MB. Software loads entries one word at a time through a write port. The port takes a side select, an entry index and an upper/lower select, and every entry is cleared by reset.

Top module: `bat_matcher`

## Requirements
- R1: After reset every entry on both sides is zero, so no lookup hits until an entry is written.
- R2: An entry can hit in user mode (`user_i`=1) only if upper bit 0 is set. It can hit in supervisor mode (`user_i`=0) only if upper bit 1 is set.
- R3: An entry's compare mask has bits 31:28 set, bits 27:17 equal to the inverse of upper bits 12:2, and bits 16:0 clear.
- R4: An entry hits when the effective address ANDed with its mask equals the upper word with bits 16:0 cleared.
- R5: The real address is (lower AND mask) OR (effective address AND NOT mask), with bits 11:0 forced to zero.
- R6: `acc_i`=2 (fetch) selects the instruction entry set. Codes 0 (load), 1 (store) and 3 select the data entry set.
- R7: When several entries hit, the one with the lowest index wins.
- R8: With NUM_ENTRIES=0 the block never hits.
- R9: A write stores `wr_data_i` into the upper word (`wr_upper_i`=1) or the lower word (`wr_upper_i`=0) of entry `wr_idx_i`, on the instruction side when `wr_instr_i`=1. Lookups see the new value from the next cycle.
- R10: On a hit, `prot_o` equals lower bits 1:0 of the winning entry. On a miss, `raddr_o` and `prot_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Entry word write strobe |
| wr_instr_i | input | 1 | Write targets the instruction set (1) or the data set (0) |
| wr_upper_i | input | 1 | Write targets the upper word (1) or the lower word (0) |
| wr_idx_i | input | IW | Entry index for the write |
| wr_data_i | input | 32 | Word to write |
| ea_i | input | 32 | Effective address |
| acc_i | input | 2 | Access type: 0 load, 1 store, 2 fetch |
| user_i | input | 1 | User mode (1) or supervisor mode (0) |
| hit_o | output | 1 | An entry matched |
| raddr_o | output | 32 | Page-aligned real address |
| prot_o | output | 2 | Protection bits of the winning entry |

## Verification
The bench probes both edges of a 128 KB block. An address one byte past the end must miss, and a design that masked too few bits would hit there. A 256 MB entry checks that the block length reaches the top of the mask: a design with a misplaced shift would pass through the wrong address bits. Overlapping entries, first with one of them then cleared, catch a design that lets the highest index win or merges results. Lookups in the opposite privilege mode or on the opposite side must miss, and a design that ignored one validity bit or shared the entry sets would wrongly hit.

// File: rtl/bat_pkg.sv
package bat_pkg;
  localparam int AW     = 32;
  localparam int PROT_W = 2;
  localparam int PAGE_W = 12;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  localparam logic [AW-1:0] IDX_FIELD = 32'hFFFE_0000;
endpackage

// File: rtl/bat_entry_file.sv
module bat_entry_file #(
  parameter int N  = 4,
  parameter int NS = 4,
  parameter int IW = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic                  upper_sel_i,
  input  logic [IW-1:0]         idx_i,
  input  logic [bat_pkg::AW-1:0] data_i,
  output logic [bat_pkg::AW-1:0] upper_o [NS],
  output logic [bat_pkg::AW-1:0] lower_o [NS]
);
  import bat_pkg::*;

  for (genvar g = 0; g < NS; g++) begin : g_ent
    logic [AW-1:0] upper_q, lower_q;
    if (g < N) begin : g_live
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          upper_q <= '0;
          lower_q <= '0;
        end else if (we_i && idx_i == IW'(g)) begin
          if (upper_sel_i) upper_q <= data_i;
          else             lower_q <= data_i;
        end
      end

      assert_upper_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && upper_sel_i && idx_i == IW'(g)) |=> upper_q == $past(data_i));
      assert_lower_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && !upper_sel_i && idx_i == IW'(g)) |=> lower_q == $past(data_i));
    end else begin : g_dead
      assign upper_q = '0;
      assign lower_q = '0;
    end
    assign upper_o[g] = upper_q;
    assign lower_o[g] = lower_q;
  end
endmodule

// File: rtl/bat_entry_cmp.sv
module bat_entry_cmp (
  input  logic [bat_pkg::AW-1:0]     upper_i,
  input  logic [bat_pkg::AW-1:0]     lower_i,
  input  logic [bat_pkg::AW-1:0]     ea_i,
  input  logic                       user_i,
  output logic                       match_o,
  output logic [bat_pkg::AW-1:0]     raddr_o,
  output logic [bat_pkg::PROT_W-1:0] prot_o
);
  import bat_pkg::*;

  logic          gate;
  logic [10:0]   blen;
  logic [AW-1:0] mask, comb;

  always_comb begin
    gate    = user_i ? upper_i[0] : upper_i[1];
    blen    = upper_i[12:2];
    // block length widens the block by clearing mask bits 27:17
    mask    = {4'hF, ~blen, 17'b0};
    match_o = gate && ((ea_i & mask) == (upper_i & IDX_FIELD));
    comb    = (lower_i & mask) | (ea_i & ~mask);
    raddr_o = {comb[AW-1:PAGE_W], {PAGE_W{1'b0}}};
    prot_o  = lower_i[PROT_W-1:0];
  end
endmodule

// File: rtl/bat_prio_sel.sv
module bat_prio_sel #(
  parameter int NS = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NS-1:0]              match_i,
  input  logic [bat_pkg::AW-1:0]     raddr_i [NS],
  input  logic [bat_pkg::PROT_W-1:0] prot_i  [NS],
  output logic                       hit_o,
  output logic [bat_pkg::AW-1:0]     raddr_o,
  output logic [bat_pkg::PROT_W-1:0] prot_o
);
  import bat_pkg::*;

  logic [NS-1:0] grant;

  always_comb begin
    grant = '0;
    for (int i = 0; i < NS; i++) begin
      if (match_i[i] && grant == '0) grant[i] = 1'b1;
    end
  end

  always_comb begin
    hit_o   = |grant;
    raddr_o = '0;
    prot_o  = '0;
    for (int i = 0; i < NS; i++) begin
      if (grant[i]) begin
        raddr_o = raddr_i[i];
        prot_o  = prot_i[i];
      end
    end
  end

  assert_single_grant_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant));
  assert_grant_tracks_match_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_i != '0) |-> ((grant & match_i) != '0) && ((grant & (grant - 1'b1 | grant)) == grant));
endmodule

// File: rtl/bat_matcher.sv
module bat_matcher #(
  parameter int NUM_ENTRIES = 4,
  localparam int NS = (NUM_ENTRIES > 0) ? NUM_ENTRIES : 1,
  localparam int IW = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          wr_instr_i,
  input  logic          wr_upper_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [31:0]   wr_data_i,
  input  logic [31:0]   ea_i,
  input  logic [1:0]    acc_i,
  input  logic          user_i,
  output logic          hit_o,
  output logic [31:0]   raddr_o,
  output logic [1:0]    prot_o
);
  import bat_pkg::*;

  logic [AW-1:0]     i_upper [NS], i_lower [NS];
  logic [AW-1:0]     d_upper [NS], d_lower [NS];
  logic [AW-1:0]     s_upper [NS], s_lower [NS];
  logic [AW-1:0]     e_raddr [NS];
  logic [PROT_W-1:0] e_prot  [NS];
  logic [NS-1:0]     e_match, e_live;
  logic              is_fetch;

  assign is_fetch = (acc_e'(acc_i) == ACC_FETCH);

  bat_entry_file #(.N(NUM_ENTRIES), .NS(NS), .IW(IW)) u_ifile (
    .clk_i, .rst_ni,
    .we_i(wr_en_i && wr_instr_i), .upper_sel_i(wr_upper_i),
    .idx_i(wr_idx_i), .data_i(wr_data_i),
    .upper_o(i_upper), .lower_o(i_lower)
  );

  bat_entry_file #(.N(NUM_ENTRIES), .NS(NS), .IW(IW)) u_dfile (
    .clk_i, .rst_ni,
    .we_i(wr_en_i && !wr_instr_i), .upper_sel_i(wr_upper_i),
    .idx_i(wr_idx_i), .data_i(wr_data_i),
    .upper_o(d_upper), .lower_o(d_lower)
  );

  for (genvar g = 0; g < NS; g++) begin : g_cmp
    assign s_upper[g] = is_fetch ? i_upper[g] : d_upper[g];
    assign s_lower[g] = is_fetch ? i_lower[g] : d_lower[g];

    bat_entry_cmp u_cmp (
      .upper_i(s_upper[g]), .lower_i(s_lower[g]),
      .ea_i, .user_i,
      .match_o(e_match[g]), .raddr_o(e_raddr[g]), .prot_o(e_prot[g])
    );
    assign e_live[g] = (g < NUM_ENTRIES) ? e_match[g] : 1'b0;
  end

  bat_prio_sel #(.NS(NS)) u_sel (
    .clk_i, .rst_ni,
    .match_i(e_live), .raddr_i(e_raddr), .prot_i(e_prot),
    .hit_o, .raddr_o, .prot_o
  );

  assert_page_aligned_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> raddr_o[PAGE_W-1:0] == '0);
  assert_miss_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (raddr_o == '0 && prot_o == '0));
  assert_no_entries_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (NUM_ENTRIES == 0) |-> !hit_o);
  assert_reset_empty_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !hit_o);
endmodule

// File: tb/bat_matcher_bench.sv
module bat_matcher_bench;
  localparam int CLK_P = 10;
  localparam int N  = 4;
  localparam int IW = 2;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0, wr_instr = 1'b0, wr_upper = 1'b0;
  logic [IW-1:0] wr_idx = '0;
  logic [31:0]   wr_data = '0, ea = '0;
  logic [1:0]    acc = 2'd0;
  logic          user = 1'b0;
  logic          hit, e_hit;
  logic [31:0]   raddr, e_raddr;
  logic [1:0]    prot, e_prot;

  bat_matcher #(.NUM_ENTRIES(N)) u_bat_matcher (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_instr_i(wr_instr),
    .wr_upper_i(wr_upper), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .ea_i(ea), .acc_i(acc), .user_i(user),
    .hit_o(hit), .raddr_o(raddr), .prot_o(prot)
  );

  bat_matcher #(.NUM_ENTRIES(0)) u_bat_matcher_empty (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_instr_i(wr_instr),
    .wr_upper_i(wr_upper), .wr_idx_i(wr_idx[0]), .wr_data_i(wr_data),
    .ea_i(ea), .acc_i(acc), .user_i(user),
    .hit_o(e_hit), .raddr_o(e_raddr), .prot_o(e_prot)
  );

  typedef struct {
    logic        hit;
    logic [31:0] ra;
    logic [1:0]  prot;
    string       tag;
  } exp_t;

  exp_t q[$];
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;
  logic [31:0] mu [2][N];
  logic [31:0] ml [2][N];

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: samples a quarter period after the driving edge
  always @(negedge clk) begin
    #(CLK_P/4);
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check({e.tag, " hit"},   32'(hit),   32'(e.hit));
      check({e.tag, " raddr"}, raddr,      e.ra);
      check({e.tag, " prot"},  32'(prot),  32'(e.prot));
      check("R8 empty-instance hit", 32'(e_hit), 32'd0);
    end
  end

  task automatic wr(input bit instr, input bit upper, input int idx, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_instr = instr; wr_upper = upper; wr_idx = IW'(idx); wr_data = d;
    if (upper) mu[instr][idx] = d; else ml[instr][idx] = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic look(input logic [31:0] a, input logic [1:0] ac, input bit u,
                      input bit eh, input logic [31:0] er, input logic [1:0] ep, input string tag);
    exp_t e;
    @(negedge clk);
    ea = a; acc = ac; user = u;
    e.hit = eh; e.ra = er; e.prot = ep; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic model(input logic [31:0] a, input logic [1:0] ac, input bit u,
                       output bit h, output logic [31:0] r, output logic [1:0] p);
    int s;
    s = (ac == 2'd2) ? 1 : 0;
    h = 1'b0; r = '0; p = '0;
    for (int i = 0; i < N; i++) begin
      logic [31:0] m;
      bit gate;
      m = {4'hF, ~mu[s][i][12:2], 17'b0};
      gate = u ? mu[s][i][0] : mu[s][i][1];
      if (!h && gate && ((a & m) == (mu[s][i] & 32'hFFFE_0000))) begin
        h = 1'b1;
        r = ((ml[s][i] & m) | (a & ~m)) & 32'hFFFF_F000;
        p = ml[s][i][1:0];
      end
    end
  endtask

  initial begin
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < N; i++) begin mu[s][i] = '0; ml[s][i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: nothing hits after reset
    look(32'h1000_0000, 2'd0, 1'b0, 1'b0, 32'h0, 2'd0, "R1 reset data");
    look(32'h0000_0000, 2'd2, 1'b1, 1'b0, 32'h0, 2'd0, "R1 reset fetch");

    // data entry 0: 128 KB at 0x1000_0000, supervisor only, prot 2
    wr(1'b0, 1'b1, 0, 32'h1000_0002);
    wr(1'b0, 1'b0, 0, 32'h8000_0002);
    look(32'h1001_2345, 2'd0, 1'b0, 1'b1, 32'h8001_2000, 2'd2, "R9 R4 R5 R10 basic hit");
    look(32'h1001_2345, 2'd1, 1'b0, 1'b1, 32'h8001_2000, 2'd2, "R6 store uses data set");
    look(32'h1001_2345, 2'd3, 1'b0, 1'b1, 32'h8001_2000, 2'd2, "R6 code 3 uses data set");
    look(32'h1001_2345, 2'd0, 1'b1, 1'b0, 32'h0, 2'd0, "R2 user blocked");
    look(32'h1001_2345, 2'd2, 1'b0, 1'b0, 32'h0, 2'd0, "R6 fetch sees empty instr set");
    look(32'h1001_FFFF, 2'd0, 1'b0, 1'b1, 32'h8001_F000, 2'd2, "R4 last byte of block");
    look(32'h1002_0000, 2'd0, 1'b0, 1'b0, 32'h0, 2'd0, "R3 R4 one past block");

    // data entry 1: 256 MB at 0x2000_0000, both modes, prot 1
    wr(1'b0, 1'b1, 1, 32'h2000_1FFF);
    wr(1'b0, 1'b0, 1, 32'h4000_0001);
    look(32'h2ABC_DEF0, 2'd0, 1'b1, 1'b1, 32'h4ABC_D000, 2'd1, "R3 R5 256MB user");
    look(32'h2FFF_FFFF, 2'd1, 1'b0, 1'b1, 32'h4FFF_F000, 2'd1, "R3 256MB supervisor top");
    look(32'h3000_0000, 2'd0, 1'b0, 1'b0, 32'h0, 2'd0, "R4 past 256MB");

    // R7 overlap: entry 2 covers entry 0's block
    wr(1'b0, 1'b1, 2, 32'h1000_0003);
    wr(1'b0, 1'b0, 2, 32'h9000_0003);
    look(32'h1000_4000, 2'd0, 1'b0, 1'b1, 32'h8000_4000, 2'd2, "R7 lowest index wins");
    look(32'h1000_4000, 2'd0, 1'b1, 1'b1, 32'h9000_4000, 2'd3, "R2 R7 user falls to entry 2");
    wr(1'b0, 1'b1, 0, 32'h0);
    look(32'h1000_4000, 2'd0, 1'b0, 1'b1, 32'h9000_4000, 2'd3, "R7 R9 cleared entry yields");

    // R6 instruction set
    wr(1'b1, 1'b1, 3, 32'h1000_0003);
    wr(1'b1, 1'b0, 3, 32'hC000_0000);
    look(32'h1000_1234, 2'd2, 1'b1, 1'b1, 32'hC000_1000, 2'd0, "R6 fetch uses instr set");
    look(32'h1000_1234, 2'd0, 1'b1, 1'b1, 32'h9000_1000, 2'd3, "R6 load ignores instr set");

    // R4 index bits inside the length field never match
    wr(1'b1, 1'b1, 0, 32'h5002_0006);
    look(32'h5002_0000, 2'd2, 1'b0, 1'b0, 32'h0, 2'd0, "R4 stray index bit under mask");

    // sweep against a requirement model
    for (int k = 0; k < 300; k++) begin
      logic [31:0] a;
      logic [1:0]  ac;
      bit u, h;
      logic [31:0] r;
      logic [1:0]  p;
      a  = $urandom;
      a[31:28] = 4'($urandom_range(0, 5));
      ac = 2'($urandom_range(0, 3));
      u  = 1'($urandom_range(0, 1));
      model(a, ac, u, h, r, p);
      look(a, ac, u, h, r, p, "R4 R5 R7 sweep");
    end

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule